// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Unit

This block generates four pulse-width-modulated outputs from one shared free-running counter. A four-bit scale value selects which sixteen-bit window of the counter is compared against each channel's sixteen-bit threshold. The period is therefore a power of two clock ticks set by the scale. Each output is active-low: it sits low while the windowed count is below the channel threshold. Because of this rule a zero threshold keeps a channel idle, and even the largest threshold leaves one inactive windowed tick per period.

Software reaches the unit through a simple word-wide register port. It selects continuous running or a single period, and it can shorten the period by restarting the counter when the windowed count meets channel 0's threshold. That restart raises a pending flag. Software clears the flag by writing zero to it, and a hold option blocks the clear.

Thresholds are not double-buffered, so a new threshold applies at once. A period and duty changed together may therefore give one mixed period.

Top module: `scalepwm_unit`

## Requirements
- R1: Register map (byte offsets). 0x00 is control: scale in bits 3:0, hold in bit 8, restart-on-match in bit 9, run-continuous in bit 12, run-single in bit 13, pending in bit 28, all other bits read 0. 0x08 is the raw 31-bit counter, readable and writable, zero-extended. 0x10 is the windowed count, read-only. 0x20+4*i is the channel i threshold, with only its low 16 bits stored. Read data appears on `bus_rdata` one clock after the address is presented.
- R2: The counter advances by one on every clock while run-continuous or run-single is set. It holds its value while both are clear.
- R3: The windowed count equals counter bits [scale+15:scale].
- R4: `pwm_n[i]` is low while the windowed count is below threshold i and high otherwise. It is registered one clock after the counter.
- R5: A threshold of 0 keeps its output high at all times.
- R6: With threshold 0xFFFF the output is still high while the windowed count is 0xFFFF.
- R7: With restart-on-match clear, the counter returns to 0 on the clock after it reaches 2^(16+scale)-1.
- R8: Run-single clears itself on the clock where the counter returns to 0, and the counter then stops.
- R9: With restart-on-match set and the counter running, the counter goes to 0 on the clock edge at which the windowed count equals threshold 0.
- R10: That restart sets the pending bit, and `irq_pend` mirrors it.
- R11: Writing 0 to bit 28 of control clears pending when the stored hold bit is 0. Writing 1 never sets pending.
- R12: While the stored hold bit is 1, no write clears pending.
- R13: After reset all registers are zero, `pwm_n` is all ones and `irq_pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwm_n | output | 4 | Active-low channel outputs |
| irq_pend | output | 1 | Pending flag |

## Verification
The properties assume that software writes the counter only through offset 0x08. They also assume that a control write in the same clock as an automatic run-single clear takes priority, so that check excuses those cycles. The stimulus loads the counter only while it is stopped. Where the counter must run, it starts and stops the counter with a known number of clocks in between, so every expected count follows from the requirements alone. Clears of the pending flag are issued only after the counter has stopped, so no restart lands in the same clock as a clear.

// File: rtl/pwmsc_pkg.sv
package pwmsc_pkg;
  localparam int BUS_W = 32;

  // byte offsets decoded by software
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_COUNT  = 'h08;
  localparam int OFS_WINDOW = 'h10;
  localparam int OFS_THRESH = 'h20;

  // control bit positions
  localparam int B_HOLD    = 8;
  localparam int B_RESTART = 9;
  localparam int B_CONT    = 12;
  localparam int B_SINGLE  = 13;
  localparam int B_PEND    = 28;
endpackage

// File: rtl/pwmsc_timebase.sv
module pwmsc_timebase #(
  parameter int CMP_W   = 16,
  parameter int SCALE_W = 4,
  parameter int CNT_W   = 31
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic               run_i,
  input  logic               restart_en_i,
  input  logic [CMP_W-1:0]   thr0_i,
  input  logic               load_i,
  input  logic [CNT_W-1:0]   load_val_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CMP_W-1:0]   window_o,
  output logic               wrap_o,
  output logic               match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] ones;
  logic [CNT_W-1:0] period_mask;
  logic             at_end;

  assign ones        = '1;
  assign shifted     = cnt_q >> scale_i;
  assign window_o    = shifted[CMP_W-1:0];
  assign period_mask = ~(ones << (CMP_W + int'(scale_i)));
  assign at_end      = (cnt_q & period_mask) == period_mask;
  assign match_o     = run_i && restart_en_i && (window_o == thr0_i);
  assign wrap_o      = run_i && (at_end || match_o);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (wrap_o)  cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmsc_channel.sv
module pwmsc_channel #(
  parameter int CMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMP_W-1:0] window_i,
  input  logic [CMP_W-1:0] thr_i,
  output logic             out_n
);
  always_ff @(posedge clk) begin
    if (rst) out_n <= 1'b1;
    else     out_n <= !(window_i < thr_i);
  end
endmodule

// File: rtl/pwmsc_regfile.sv
module pwmsc_regfile
  import pwmsc_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CMP_W    = 16,
  parameter int SCALE_W  = 4,
  parameter int CNT_W    = 31,
  parameter int ADDR_W   = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [BUS_W-1:0]          wdata_i,
  output logic [BUS_W-1:0]          rdata_o,
  input  logic [CNT_W-1:0]          cnt_i,
  input  logic [CMP_W-1:0]          window_i,
  input  logic                      wrap_i,
  input  logic                      match_i,
  output logic [SCALE_W-1:0]        scale_o,
  output logic                      hold_o,
  output logic                      restart_en_o,
  output logic                      cont_o,
  output logic                      single_o,
  output logic                      pend_o,
  output logic                      ctrl_wr_o,
  output logic                      cnt_wr_o,
  output logic [CHANNELS*CMP_W-1:0] thr_o
);
  logic [CMP_W-1:0] thr_q [CHANNELS];
  logic [BUS_W-1:0] rd_next;

  assign ctrl_wr_o = we_i && (int'(addr_i) == OFS_CTRL);
  assign cnt_wr_o  = we_i && (int'(addr_i) == OFS_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      scale_o      <= '0;
      hold_o       <= 1'b0;
      restart_en_o <= 1'b0;
      cont_o       <= 1'b0;
      single_o     <= 1'b0;
    end else if (ctrl_wr_o) begin
      scale_o      <= wdata_i[SCALE_W-1:0];
      hold_o       <= wdata_i[B_HOLD];
      restart_en_o <= wdata_i[B_RESTART];
      cont_o       <= wdata_i[B_CONT];
      single_o     <= wdata_i[B_SINGLE];
    end else if (wrap_i) begin
      single_o     <= 1'b0;
    end
  end

  // a restart wins over a clearing write; the stored hold bit gates clears
  always_ff @(posedge clk) begin
    if (rst)                                    pend_o <= 1'b0;
    else if (match_i)                           pend_o <= 1'b1;
    else if (ctrl_wr_o && !hold_o && !wdata_i[B_PEND]) pend_o <= 1'b0;
  end

  for (genvar i = 0; i < CHANNELS; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)
        thr_q[i] <= '0;
      else if (we_i && int'(addr_i) == OFS_THRESH + 4 * i)
        thr_q[i] <= wdata_i[CMP_W-1:0];
    end
    assign thr_o[i*CMP_W +: CMP_W] = thr_q[i];
  end

  always_comb begin
    rd_next = '0;
    if (int'(addr_i) == OFS_CTRL) begin
      rd_next[SCALE_W-1:0] = scale_o;
      rd_next[B_HOLD]      = hold_o;
      rd_next[B_RESTART]   = restart_en_o;
      rd_next[B_CONT]      = cont_o;
      rd_next[B_SINGLE]    = single_o;
      rd_next[B_PEND]      = pend_o;
    end else if (int'(addr_i) == OFS_COUNT) begin
      rd_next = BUS_W'(cnt_i);
    end else if (int'(addr_i) == OFS_WINDOW) begin
      rd_next = BUS_W'(window_i);
    end
    for (int i = 0; i < CHANNELS; i++)
      if (int'(addr_i) == OFS_THRESH + 4 * i) rd_next = BUS_W'(thr_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end
endmodule

// File: rtl/scalepwm_unit.sv
module scalepwm_unit
  import pwmsc_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int CMP_W    = 16,
  parameter int SCALE_W  = 4,
  parameter int ADDR_W   = 8,
  localparam int CNT_W   = CMP_W + (1 << SCALE_W) - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  output logic [CHANNELS-1:0] pwm_n,
  output logic                irq_pend
);
  logic [SCALE_W-1:0]        scale;
  logic                      hold, restart_en, cont, single, pend;
  logic                      ctrl_wr, cnt_wr, run, wrap, match;
  logic [CHANNELS*CMP_W-1:0] thr_flat;
  logic [CNT_W-1:0]          cnt;
  logic [CMP_W-1:0]          window;

  assign run      = cont || single;
  assign irq_pend = pend;

  pwmsc_regfile #(
    .CHANNELS(CHANNELS), .CMP_W(CMP_W), .SCALE_W(SCALE_W),
    .CNT_W(CNT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .cnt_i(cnt),
    .window_i(window), .wrap_i(wrap), .match_i(match),
    .scale_o(scale), .hold_o(hold), .restart_en_o(restart_en),
    .cont_o(cont), .single_o(single), .pend_o(pend),
    .ctrl_wr_o(ctrl_wr), .cnt_wr_o(cnt_wr), .thr_o(thr_flat)
  );

  pwmsc_timebase #(
    .CMP_W(CMP_W), .SCALE_W(SCALE_W), .CNT_W(CNT_W)
  ) u_tb (
    .clk(clk), .rst(rst), .scale_i(scale), .run_i(run),
    .restart_en_i(restart_en), .thr0_i(thr_flat[CMP_W-1:0]),
    .load_i(cnt_wr), .load_val_i(bus_wdata[CNT_W-1:0]),
    .cnt_o(cnt), .window_o(window), .wrap_o(wrap), .match_o(match)
  );

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    pwmsc_channel #(.CMP_W(CMP_W)) u_ch (
      .clk(clk), .rst(rst), .window_i(window),
      .thr_i(thr_flat[i*CMP_W +: CMP_W]), .out_n(pwm_n[i])
    );
  end
endmodule

// File: rtl/pwmsc_chk.sv
module pwmsc_chk #(
  parameter int CHANNELS = 4,
  parameter int CMP_W    = 16,
  parameter int CNT_W    = 31
) (
  input logic                clk,
  input logic                rst,
  input logic [CNT_W-1:0]    cnt,
  input logic [CMP_W-1:0]    window,
  input logic [CMP_W-1:0]    thr0,
  input logic                run,
  input logic                wrap,
  input logic                match,
  input logic                single,
  input logic                hold,
  input logic                pend,
  input logic                ctrl_wr,
  input logic                cnt_wr,
  input logic [CHANNELS-1:0] pwm_n
);
  // R5
  thr_zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (thr0 == '0) |=> pwm_n[0]);
  // R6
  full_window_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (window == '1) |=> (&pwm_n));
  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(cnt));
  // R8
  single_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (single && wrap && !ctrl_wr) |=> !single);
  // R9
  match_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (match && !cnt_wr) |=> (cnt == '0));
  // R10
  match_pend_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> pend);
  // R12
  hold_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && pend) |=> pend);
endmodule

bind scalepwm_unit pwmsc_chk #(
  .CHANNELS(CHANNELS), .CMP_W(CMP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt), .window(window),
  .thr0(thr_flat[CMP_W-1:0]), .run(run), .wrap(wrap), .match(match),
  .single(single), .hold(hold), .pend(pend), .ctrl_wr(ctrl_wr),
  .cnt_wr(cnt_wr), .pwm_n(pwm_n)
);

// File: tb/scalepwm_unit_test.sv
module scalepwm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_n;
  logic        irq_pend;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_req = 1'b0;
  logic        rd_due = 1'b0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  scalepwm_unit uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_n(pwm_n),
    .irq_pend(irq_pend)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  always @(posedge clk) rd_due <= rd_req;
  always @(negedge clk) begin
    if (rd_due && exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R13 reset state
    chk({28'd0, pwm_n}, 32'hF, "R13 pwm_n");
    chk({31'd0, irq_pend}, 32'h0, "R13 irq_pend");
    rd(8'h00, 32'h0, "R13 ctrl");
    rd(8'h08, 32'h0, "R13 count");
    rd(8'h20, 32'h0, "R13 thr0");

    // R1 unsupported bits read zero, thresholds keep low 16 bits
    wr(8'h00, 32'h0101_0404);
    rd(8'h00, 32'h0000_0004, "R1 ctrl readback");
    wr(8'h24, 32'hFFFF_1235);
    wr(8'h28, 32'h0000_1234);
    wr(8'h2C, 32'h0000_FFFF);
    rd(8'h24, 32'h0000_1235, "R1 thr1");
    rd(8'h2C, 32'h0000_FFFF, "R1 thr3");

    // R3 window, R4/R5 outputs
    wr(8'h08, 32'h0001_2345);
    rd(8'h10, 32'h0000_1234, "R3 window scale4");
    rd(8'h08, 32'h0001_2345, "R1 count readback");
    idle(1);
    chk({28'd0, pwm_n}, 32'h5, "R4 R5 pwm_n pattern");

    // R6 full window leaves every output high
    wr(8'h08, 32'h000F_FFF0);
    idle(2);
    chk({28'd0, pwm_n}, 32'hF, "R6 pwm_n at full window");
    rd(8'h10, 32'h0000_FFFF, "R6 window");

    // R2 counting and holding
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h0000_1000);
    idle(8);
    wr(8'h00, 32'h0);
    rd(8'h08, 32'd9, "R2 run count");
    idle(5);
    rd(8'h08, 32'd9, "R2 stopped hold");

    // R7 natural wrap, scale 0 and scale 1
    wr(8'h08, 32'h0000_FFFE);
    wr(8'h00, 32'h0000_1000);
    idle(2);
    wr(8'h00, 32'h0);
    rd(8'h08, 32'd1, "R7 wrap scale0");
    wr(8'h00, 32'h1);
    wr(8'h08, 32'h0001_FFFE);
    wr(8'h00, 32'h0000_1001);
    idle(2);
    wr(8'h00, 32'h1);
    rd(8'h08, 32'd1, "R7 wrap scale1");

    // R8 single period
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h0000_FFFE);
    wr(8'h00, 32'h0000_2000);
    idle(5);
    rd(8'h08, 32'd0, "R8 stopped at zero");
    rd(8'h00, 32'h0, "R8 single cleared");

    // R9/R10 restart on threshold 0
    wr(8'h20, 32'd5);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1000_1200);
    idle(12);
    wr(8'h00, 32'h1000_0200);
    rd(8'h08, 32'd1, "R9 restart count");
    rd(8'h00, 32'h1000_0200, "R10 pend set");
    chk({31'd0, irq_pend}, 32'h1, "R10 irq_pend");

    // R11 clear and no set by write
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R11 pend cleared");
    chk({31'd0, irq_pend}, 32'h0, "R11 irq_pend low");
    wr(8'h00, 32'h1000_0000);
    rd(8'h00, 32'h0, "R11 write one no set");

    // R12 hold
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h1000_1300);
    idle(12);
    wr(8'h00, 32'h1000_0300);
    chk({31'd0, irq_pend}, 32'h1, "R12 pend raised");
    wr(8'h00, 32'h0000_0100);
    rd(8'h00, 32'h1000_0100, "R12 pend held");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h1000_0000, "R12 stored hold blocks clear");
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R11 clear after hold dropped");

    idle(3);
    finish_run();
  end
endmodule